// File: doc/BRIEF.md
# Register Read-After-Write Stall Detector

This block is the interlock for a five-stage in-order pipeline whose instructions come in four kinds: ALU operations, loads, stores and branch-if-equal. Before the decode stage reads the register file and moves the program counter on, it raises a check request. The request carries the incoming instruction's kind and its two source register numbers. The detector answers with a grant only when no older, still-unfinished instruction is due to write one of the registers the incoming instruction reads. While any such conflict exists the grant is withheld, and decode stalls.

Three places can hold an older instruction:
- the slot between execute and memory access,
- the slot waiting for writeback,
- a register-file write that has been issued but not yet completed.

Each place reports a busy flag, the kind of the instruction it holds, and its destination register. Only ALU operations and loads write the register bank, so only those two kinds can cause a conflict. An incoming load reads only its first source register. ALU, store and branch instructions read both source registers. The conflict logic is combinational. The grant is registered, so it answers one cycle after the request is seen.

Top module: `hazard_interlock`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `chk_ack` is 0.
- R2: If `chk_req` is 0 at a rising edge, `chk_ack` is 0 after that edge.
- R3: If `chk_req` is 1 at a rising edge and no slot is busy, `chk_ack` is 1 after that edge.
- R4: A busy slot whose kind is store (2'b10) or branch (2'b11) never withholds the grant, whatever its destination.
- R5: Incoming kinds ALU (2'b00), store (2'b10) and branch (2'b11) read both source registers. For these, `chk_ack` stays 0 after an edge where `chk_req` is 1 and some busy slot of kind ALU (2'b00) or load (2'b01) has a destination equal to `rs_a` or to `rs_b`.
- R6: For an incoming load (2'b01), only `rs_a` is compared. A writing slot whose destination equals only `rs_b` does not withhold the grant.
- R7: The three slots are checked independently. A conflict in any one of them alone withholds the grant. Slot index 0 is execute-to-memory, 1 is memory-to-writeback, and 2 is the pending register write.
- R8: Register number 0 gets no special treatment. A match on index 0 stalls like any other index.
- R9: A slot whose busy flag is 0 is ignored, whatever its kind and destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| chk_req | input | 1 | Decode asks for permission to read registers |
| chk_type | input | 2 | Kind of the incoming instruction (00 ALU, 01 load, 10 store, 11 branch) |
| rs_a | input | 5 | First source register of the incoming instruction |
| rs_b | input | 5 | Second source register of the incoming instruction |
| slot_busy | input | 3 | Busy flag per slot (0 execute-to-memory, 1 memory-to-writeback, 2 pending write) |
| slot_kind | input | 6 | Instruction kind per slot, 2 bits each, slot 0 in the low bits |
| slot_dst | input | 15 | Destination register per slot, 5 bits each, slot 0 in the low bits |
| chk_ack | output | 1 | Grant: no read-after-write conflict was present at the last edge |

## Verification
Every result of this block is due exactly one cycle after its stimulus. The grant reflects the request and slot state sampled at the preceding rising edge. The bench therefore drives a new stimulus on each falling edge and compares `chk_ack` at the next falling edge. The expected grant comes from a behavioural model evaluated on the inputs that were present at the edge in between. Directed steps cover each requirement, and a pseudo-random run mixes kinds, busy flags and colliding register numbers.

// File: rtl/hz_pkg.sv
// Shared encodings for the register-hazard interlock.
// Assumes a 2-bit instruction kind code used identically by decode and by every in-flight slot.
package hz_pkg;
    typedef enum logic [1:0] {
        OP_ALU   = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_BEQ   = 2'b11
    } op_kind_t;

    // True when an instruction of this kind writes the register bank.
    function automatic logic kind_writes(input logic [1:0] k);
        return (k == OP_ALU) || (k == OP_LOAD);
    endfunction

    // True when an instruction of this kind reads its second source register.
    function automatic logic kind_reads_b(input logic [1:0] k);
        return k != OP_LOAD;
    endfunction
endpackage

// File: rtl/hz_slot_cmp.sv
// Conflict test for one in-flight slot.
// Raises hit when the slot is busy, its instruction writes the register bank,
// and its destination matches a register the incoming instruction reads.
// Assumes every index, including 0, is a real register.
module hz_slot_cmp #(
    parameter int RW = 5
) (
    input  logic          busy,
    input  logic [1:0]    kind,
    input  logic [RW-1:0] dst,
    input  logic [1:0]    in_kind,
    input  logic [RW-1:0] rd_a,
    input  logic [RW-1:0] rd_b,
    output logic          hit
);
    import hz_pkg::*;

    logic match_a;
    logic match_b;

    // Per-source destination match; the second source counts only when it is read.
    always_comb begin
        match_a = (dst == rd_a);
        match_b = kind_reads_b(in_kind) && (dst == rd_b);
        hit     = busy && kind_writes(kind) && (match_a || match_b);
    end
endmodule

// File: rtl/hz_grant_reg.sv
// Registered grant for the check handshake.
// Grants one cycle after a request seen with no conflict; idles low when no request is present.
module hz_grant_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic conflict,
    output logic ack
);
    // Capture the grant decision at each rising edge; synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= req && !conflict;
    end
endmodule

// File: rtl/hazard_interlock.sv
// Read-after-write interlock for decode.
// Compares the incoming source registers against every in-flight slot and withholds
// the registered grant while any slot still has to write one of them.
// Assumes the slot busy flags are set on stage accept and cleared on downstream acknowledge.
module hazard_interlock #(
    parameter int RW    = 5,
    parameter int NSLOT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chk_req,
    input  logic [1:0]            chk_type,
    input  logic [RW-1:0]         rs_a,
    input  logic [RW-1:0]         rs_b,
    input  logic [NSLOT-1:0]      slot_busy,
    input  logic [2*NSLOT-1:0]    slot_kind,
    input  logic [RW*NSLOT-1:0]   slot_dst,
    output logic                  chk_ack
);
    logic [NSLOT-1:0] slot_hit;
    logic             any_conflict;

    // One comparator per in-flight slot.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        hz_slot_cmp #(.RW(RW)) u_cmp (
            .busy    (slot_busy[s]),
            .kind    (slot_kind[2*s +: 2]),
            .dst     (slot_dst[RW*s +: RW]),
            .in_kind (chk_type),
            .rd_a    (rs_a),
            .rd_b    (rs_b),
            .hit     (slot_hit[s])
        );
    end

    // Merge the per-slot conflicts.
    always_comb any_conflict = |slot_hit;

    hz_grant_reg u_grant (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (chk_req),
        .conflict (any_conflict),
        .ack      (chk_ack)
    );
endmodule

// File: rtl/hazard_interlock_chk.sv
// Property checker for hazard_interlock, attached with bind.
// Observes ports only.
module hazard_interlock_chk #(
    parameter int RW    = 5,
    parameter int NSLOT = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                chk_req,
    input logic [1:0]          chk_type,
    input logic [RW-1:0]       rs_a,
    input logic [RW-1:0]       rs_b,
    input logic [NSLOT-1:0]    slot_busy,
    input logic [2*NSLOT-1:0]  slot_kind,
    input logic [RW*NSLOT-1:0] slot_dst,
    input logic                chk_ack
);
    // R1
    reset_release_chk: assert property (@(posedge clk) $rose(rst_n) |-> !chk_ack);

    // R2
    idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_req |=> !chk_ack);

    // R3
    empty_pipe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && slot_busy == '0) |=> chk_ack);

    // R5
    alu_a_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && slot_busy[0] && slot_kind[1:0] == 2'b00 && slot_dst[RW-1:0] == rs_a)
        |=> !chk_ack);

    // R8
    zero_reg_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && rs_a == '0 && slot_busy[NSLOT-1]
         && slot_kind[2*NSLOT-1 -: 2] == 2'b01 && slot_dst[RW*NSLOT-1 -: RW] == '0)
        |=> !chk_ack);
endmodule

bind hazard_interlock hazard_interlock_chk #(.RW(RW), .NSLOT(NSLOT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_req   (chk_req),
    .chk_type  (chk_type),
    .rs_a      (rs_a),
    .rs_b      (rs_b),
    .slot_busy (slot_busy),
    .slot_kind (slot_kind),
    .slot_dst  (slot_dst),
    .chk_ack   (chk_ack)
);

// File: tb/sim_hazard_interlock.sv
// Bench for hazard_interlock: behavioural reference model compared every cycle.
module sim_hazard_interlock;
    localparam int RW = 5;
    localparam int NS = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            chk_req = 1'b0;
    logic [1:0]      chk_type = 2'b00;
    logic [RW-1:0]   rs_a = '0;
    logic [RW-1:0]   rs_b = '0;
    logic [NS-1:0]   slot_busy = '0;
    logic [2*NS-1:0] slot_kind = '0;
    logic [RW*NS-1:0] slot_dst = '0;
    logic            chk_ack;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    hazard_interlock #(.RW(RW), .NSLOT(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .chk_req(chk_req), .chk_type(chk_type),
        .rs_a(rs_a), .rs_b(rs_b), .slot_busy(slot_busy), .slot_kind(slot_kind),
        .slot_dst(slot_dst), .chk_ack(chk_ack)
    );

    // Reference: would the grant be given for the current inputs?
    function automatic bit model_grant();
        bit blocked = 0;
        if (!chk_req) return 0;
        for (int s = 0; s < NS; s++) begin
            int k = int'(slot_kind[2*s +: 2]);
            int d = int'(slot_dst[RW*s +: RW]);
            if (slot_busy[s] && (k == 0 || k == 1)) begin
                if (d == int'(rs_a)) blocked = 1;
                if (chk_type != 2'b01 && d == int'(rs_b)) blocked = 1;
            end
        end
        return !blocked;
    endfunction

    task automatic check(input string tag, input bit exp);
        n_run++;
        if (chk_ack !== exp) begin
            n_fail++;
            $display("FAIL %s: chk_ack=%b expected %b", tag, chk_ack, exp);
        end
    endtask

    // Apply one stimulus on a falling edge; compare one cycle later.
    task automatic step(input string tag, input bit req, input logic [1:0] ty,
                        input int a, input int b, input logic [NS-1:0] busy,
                        input logic [2*NS-1:0] kind, input logic [RW*NS-1:0] dst);
        bit exp;
        chk_req = req; chk_type = ty; rs_a = RW'(a); rs_b = RW'(b);
        slot_busy = busy; slot_kind = kind; slot_dst = dst;
        exp = model_grant();
        @(posedge clk);
        @(negedge clk);
        check(tag, exp);
    endtask

    function automatic logic [RW*NS-1:0] dsts(input int d0, input int d1, input int d2);
        return {RW'(d2), RW'(d1), RW'(d0)};
    endfunction

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: during reset
        chk_req = 1'b1;
        @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;
        chk_req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", 1'b0);
        // R2
        step("R2", 0, 2'b00, 1, 2, 3'b000, 6'b0, dsts(0, 0, 0));
        // R3
        step("R3", 1, 2'b00, 1, 2, 3'b000, 6'b0, dsts(1, 2, 1));
        step("R2", 0, 2'b00, 1, 2, 3'b000, 6'b0, dsts(0, 0, 0));
        // R4: store and branch in flight with matching dst
        step("R4", 1, 2'b00, 4, 5, 3'b011, {2'b00, 2'b11, 2'b10}, dsts(4, 5, 0));
        // R5: ALU reader blocked on b via slot 1 ALU
        step("R5", 1, 2'b00, 7, 9, 3'b010, {2'b00, 2'b00, 2'b00}, dsts(0, 9, 0));
        // R5: store reader blocked on a via load
        step("R5", 1, 2'b10, 3, 8, 3'b001, {2'b00, 2'b00, 2'b01}, dsts(3, 0, 0));
        // R5: branch reader blocked on b
        step("R5", 1, 2'b11, 3, 8, 3'b100, {2'b01, 2'b00, 2'b00}, dsts(0, 0, 8));
        // R6: load reader, only b matches -> granted
        step("R6", 1, 2'b01, 3, 8, 3'b111, {2'b00, 2'b01, 2'b00}, dsts(8, 8, 8));
        // R6: load reader, a matches -> stall
        step("R6", 1, 2'b01, 3, 8, 3'b010, {2'b00, 2'b00, 2'b00}, dsts(0, 3, 0));
        // R7: each slot alone
        for (int s = 0; s < NS; s++) begin
            logic [NS-1:0] bz = NS'(1) << s;
            step("R7", 1, 2'b00, 12, 13, bz, 6'b0, dsts(12, 12, 12));
        end
        // R8: register 0
        step("R8", 1, 2'b00, 0, 0, 3'b001, 6'b0, dsts(0, 31, 31));
        step("R8", 1, 2'b01, 0, 5, 3'b100, {2'b01, 2'b00, 2'b00}, dsts(31, 31, 0));
        // R9: matching dst but not busy
        step("R9", 1, 2'b00, 6, 6, 3'b000, {2'b01, 2'b00, 2'b01}, dsts(6, 6, 6));
        step("R9", 1, 2'b00, 6, 6, 3'b010, {2'b01, 2'b00, 2'b01}, dsts(6, 1, 6));
        // R7: mixed pseudo-random traffic with small register range to force collisions
        for (int i = 0; i < 400; i++) begin
            step("R7", bit'($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)),
                 $urandom_range(0, 3), $urandom_range(0, 3), NS'($urandom),
                 (2*NS)'($urandom),
                 dsts($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)));
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule